// File: doc/BRIEF.md
# Prescaled Multi-Source Timer Channel

This block is a single channel of a timer/counter unit. Software reaches it over a simple 32-bit register bus. The channel takes its count events from one of three sources:

- the bus clock itself;
- a slow real-time clock input;
- an external crystal clock input.

The chosen source passes through a prescaler that divides by a power of four. The prescaled ticks advance a 16-bit up-counter. When the counter reaches a programmable full value, the channel emits a one-cycle completion pulse. On the next tick after that, the counter returns to zero.

Two separate switches decide whether the counter runs. The first is a clock-supply gate. The second is a counter enable. Each switch has its own write-one-to-set register and its own write-one-to-clear register, and both report through a status register. The control register holds the source and the prescale setting. It is writable only while the supply is ungated, so software must open the gate before it reprograms the channel. With the full value at 0xFFFF the channel becomes a free-running 16-bit counter that wraps, which is how it is used as a time base. With a smaller full value it serves as a periodic or one-shot event timer.

Top module: `timer_chan`

## Requirements
- R1: After reset the supply is gated (status bit 0 = 1), the counter is disabled (status bit 1 = 0), the control register reads 0, the full value reads 0xFFFF, the counter reads 0 and `doneSet` is low.
- R2: Word addresses are 0 control, 1 full value, 2 counter, 3 gate-set, 4 gate-clear, 5 status, 6 enable-set and 7 enable-clear. Register contents read back right-aligned with zero upper bits. Addresses 3, 4, 6 and 7 always read 0.
- R3: Writing 1 in bit 0 of address 3 gates the supply, and writing 1 in bit 0 of address 4 ungates it. Status bit 0 reads 1 while the supply is gated.
- R4: Writing 1 in bit 0 of address 6 enables the counter, and writing 1 in bit 0 of address 7 disables it. Status bit 1 reads 1 while the counter is enabled.
- R5: A write to the control register (bits [5:0]) takes effect only while the supply is ungated. While the supply is gated the write is ignored.
- R6: Control bits [2:0] select the source as a one-hot code: 001 is the bus clock (one event per cycle), 010 is the real-time clock input and 100 is the external clock input. Any other code produces no events.
- R7: Control bits [5:3] hold n, and the prescaler divides the source events by 4^n for n = 0 to 5. The values 6 and 7 divide by 1024.
- R8: The counter advances by exactly one per prescaled tick, and only while the counter is enabled and the supply is ungated. Otherwise it holds its value.
- R9: On a tick where the counter equals the full value, the counter returns to 0. On a tick that brings the counter to the full value, `doneSet` is high for exactly the following clock cycle.
- R10: With the full value at 0xFFFF the counter wraps from 0xFFFF to 0 and keeps running, and the match pulse still fires.
- R11: A write to the counter address loads bits [15:0] at that clock edge. The load takes priority over a tick in the same cycle, and that cycle produces no pulse.
- R12: The prescaler restarts from zero when an accepted control write changes the control value, and when the counter enable changes state.
- R13: Each slow clock input passes through a two-stage synchronizer followed by a rising-edge detector. Every rising edge becomes exactly one source event in the bus clock domain.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; also the first clock source |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe for the addressed register |
| addr | input | 3 | Word address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for `addr` |
| rtcClkIn | input | 1 | Slow real-time clock input, asynchronous |
| extClkIn | input | 1 | External crystal clock input, asynchronous |
| doneSet | output | 1 | One-cycle pulse when the counter matches the full value |

## Verification
The bench targets five corner cases. Each one is listed below with the failure it exposes.

- **Prescaler restart on a change to a smaller ratio.** A design that keeps the old phase leaves its prescaler count above the new limit. It would then stall for about a thousand cycles instead of ticking after four.
- **Counter reload to just below 0xFFFF with a full value of 0xFFFF.** A design with an off-by-one in the wrap or match logic would produce the wrong number of pulses, or land on the wrong count afterwards.
- **Control writes while the supply is gated.** A design that accepts these writes would read back the new source setting.
- **Both disable paths (gate and enable).** A design that ignores either one would keep counting.
- **Slow-input pulse trains and the illegal source code 011.** These show whether each rising edge is counted exactly once and whether a bad source code is silently counted.

// File: rtl/timer_chan_pkg.sv
package timer_chan_pkg;

  localparam int DATA_W = 32;
  localparam int ADDR_W = 3;
  localparam int CNT_W  = 16;
  localparam int SRC_W  = 3;
  localparam int PS_W   = 3;
  localparam int CTRL_W = SRC_W + PS_W;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL     = 3'd0,
    REG_FULL     = 3'd1,
    REG_COUNT    = 3'd2,
    REG_GATE_SET = 3'd3,
    REG_GATE_CLR = 3'd4,
    REG_STATUS   = 3'd5,
    REG_RUN_SET  = 3'd6,
    REG_RUN_CLR  = 3'd7
  } reg_idx_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic             cntLoad;
    logic [CNT_W-1:0] cntValue;
    logic             preRestart;
  } path_strobe_t;

endpackage

// File: rtl/timer_chan_ctrl.sv
module timer_chan_ctrl
  import timer_chan_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [CNT_W-1:0]  countValue,
  output logic [DATA_W-1:0] rdata,
  output path_strobe_t      strb,
  output logic              active,
  output logic [SRC_W-1:0]  srcSel,
  output logic [PS_W-1:0]   psSel,
  output logic [CNT_W-1:0]  fullValue
);

  logic              gateQ;
  logic              runQ;
  logic [CTRL_W-1:0] ctrlQ;
  logic [CNT_W-1:0]  fullQ;

  logic ctrlAccept, gateSetHit, gateClrHit, runSetHit, runClrHit;
  logic wdataUnused;

  assign wdataUnused = ^wdata[DATA_W-1:CNT_W];

  assign ctrlAccept = wrEn && (addr == REG_CTRL) && !gateQ;
  assign gateSetHit = wrEn && (addr == REG_GATE_SET) && wdata[0];
  assign gateClrHit = wrEn && (addr == REG_GATE_CLR) && wdata[0];
  assign runSetHit  = wrEn && (addr == REG_RUN_SET) && wdata[0];
  assign runClrHit  = wrEn && (addr == REG_RUN_CLR) && wdata[0];

  always_comb begin
    strb.cntLoad    = wrEn && (addr == REG_COUNT);
    strb.cntValue   = wdata[CNT_W-1:0];
    strb.preRestart = (ctrlAccept && (wdata[CTRL_W-1:0] != ctrlQ)) ||
                      (runSetHit && !runQ) || (runClrHit && runQ);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gateQ <= 1'b1;
      runQ  <= 1'b0;
      ctrlQ <= '0;
      fullQ <= '1;
    end else begin
      if (ctrlAccept) ctrlQ <= wdata[CTRL_W-1:0];
      if (wrEn && (addr == REG_FULL)) fullQ <= wdata[CNT_W-1:0];
      if (gateSetHit)      gateQ <= 1'b1;
      else if (gateClrHit) gateQ <= 1'b0;
      if (runSetHit)       runQ <= 1'b1;
      else if (runClrHit)  runQ <= 1'b0;
    end
  end

  assign active    = runQ && !gateQ;
  assign srcSel    = ctrlQ[SRC_W-1:0];
  assign psSel     = ctrlQ[CTRL_W-1:SRC_W];
  assign fullValue = fullQ;

  always_comb begin
    case (addr)
      REG_CTRL:   rdata = DATA_W'(ctrlQ);
      REG_FULL:   rdata = DATA_W'(fullQ);
      REG_COUNT:  rdata = DATA_W'(countValue);
      REG_STATUS: rdata = DATA_W'({runQ, gateQ});
      default:    rdata = '0;
    endcase
  end

  // R5: control register frozen while gated
  assert_gated_ctrl_frozen_R5: assert property (@(posedge clk) disable iff (!rstN)
    gateQ |=> $stable(ctrlQ));

  // R3: gate-set write leaves the supply gated
  assert_gate_set_takes_R3: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == REG_GATE_SET && wdata[0]) |=> gateQ);

  // R4: enable-clear write leaves the counter disabled
  assert_run_clear_takes_R4: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == REG_RUN_CLR && wdata[0] && !(addr == REG_RUN_SET)) |=> !runQ);

endmodule

// File: rtl/timer_chan_path.sv
module timer_chan_path
  import timer_chan_pkg::*;
#(
  parameter int MAX_PS      = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rtcClkIn,
  input  logic             extClkIn,
  input  path_strobe_t     strb,
  input  logic             active,
  input  logic [SRC_W-1:0] srcSel,
  input  logic [PS_W-1:0]  psSel,
  input  logic [CNT_W-1:0] fullValue,
  output logic [CNT_W-1:0] countValue,
  output logic             doneSet
);

  localparam int PRE_W  = 2 * MAX_PS;
  localparam int N_SLOW = 2;

  logic [N_SLOW-1:0] slowIn, slowEdge;
  assign slowIn = {extClkIn, rtcClkIn};

  for (genvar i = 0; i < N_SLOW; i++) begin : g_sync
    logic [SYNC_STAGES:0] chainQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chainQ <= '0;
      else       chainQ <= {chainQ[SYNC_STAGES-1:0], slowIn[i]};
    end
    assign slowEdge[i] = chainQ[SYNC_STAGES-1] & ~chainQ[SYNC_STAGES];
  end

  logic srcTick;
  always_comb begin
    case (srcSel)
      3'b001:  srcTick = 1'b1;
      3'b010:  srcTick = slowEdge[0];
      3'b100:  srcTick = slowEdge[1];
      default: srcTick = 1'b0;
    endcase
  end

  logic [PS_W-1:0]  psEff;
  logic [PRE_W-1:0] preLimit, preQ;
  logic             divTick;

  assign psEff    = (psSel > PS_W'(MAX_PS)) ? PS_W'(MAX_PS) : psSel;
  assign preLimit = ~({PRE_W{1'b1}} << {psEff, 1'b0});
  assign divTick  = active && srcTick && (preQ == preLimit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                preQ <= '0;
    else if (strb.preRestart) preQ <= '0;
    else if (active && srcTick) preQ <= divTick ? '0 : preQ + 1'b1;
  end

  logic [CNT_W-1:0] countQ, nextCount;
  logic             doneQ;

  assign nextCount = (countQ == fullValue) ? '0 : countQ + 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countQ <= '0;
      doneQ  <= 1'b0;
    end else begin
      if (strb.cntLoad)  countQ <= strb.cntValue;
      else if (divTick)  countQ <= nextCount;
      doneQ <= divTick && !strb.cntLoad && (nextCount == fullValue);
    end
  end

  assign countValue = countQ;
  assign doneSet    = doneQ;

  // R9: a pulse follows a tick that reached the full value
  assert_done_matches_full_R9: assert property (@(posedge clk) disable iff (!rstN)
    doneSet |-> (countQ == $past(fullValue)));

  // R8: no counting while disabled or gated
  assert_idle_holds_count_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!active && !strb.cntLoad) |=> $stable(countQ));

  // R11: without a load the counter only holds, steps by one, or returns to zero
  assert_count_step_R11: assert property (@(posedge clk) disable iff (!rstN)
    !strb.cntLoad |=> (countQ == $past(countQ) || countQ == $past(countQ) + 1'b1 ||
                       countQ == '0));

endmodule

// File: rtl/timer_chan.sv
module timer_chan
  import timer_chan_pkg::*;
#(
  parameter int MAX_PS      = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              rtcClkIn,
  input  logic              extClkIn,
  output logic              doneSet
);

  path_strobe_t     strb;
  logic             active;
  logic [SRC_W-1:0] srcSel;
  logic [PS_W-1:0]  psSel;
  logic [CNT_W-1:0] fullValue, countValue;

  timer_chan_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wdata(wdata),
    .countValue(countValue), .rdata(rdata), .strb(strb), .active(active),
    .srcSel(srcSel), .psSel(psSel), .fullValue(fullValue)
  );

  timer_chan_path #(.MAX_PS(MAX_PS), .SYNC_STAGES(SYNC_STAGES)) u_path (
    .clk(clk), .rstN(rstN), .rtcClkIn(rtcClkIn), .extClkIn(extClkIn),
    .strb(strb), .active(active), .srcSel(srcSel), .psSel(psSel),
    .fullValue(fullValue), .countValue(countValue), .doneSet(doneSet)
  );

endmodule

// File: tb/timer_chan_tb.sv
module timer_chan_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [31:0] wdata = 32'd0;
  logic        rtcClkIn = 1'b0;
  logic        extClkIn = 1'b0;
  logic [31:0] rdata;
  logic        doneSet;

  always #5 clk = ~clk;

  timer_chan u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wdata(wdata),
    .rdata(rdata), .rtcClkIn(rtcClkIn), .extClkIn(extClkIn), .doneSet(doneSet)
  );

  int checks = 0;
  int errors = 0;
  int doneCnt = 0;

  // Behavioural reference model
  bit mGated, mRun, mDone;
  int mCtrl, mFull, mCount, mPre;
  bit r1, r2, r3, e1, e2, e3;
  int ps, lim, nxt, src;
  bit tick, act, div, load, restart;

  always @(posedge clk) begin
    if (!rstN) begin
      mGated = 1; mRun = 0; mDone = 0;
      mCtrl = 0; mFull = 65535; mCount = 0; mPre = 0;
      r1 = 0; r2 = 0; r3 = 0; e1 = 0; e2 = 0; e3 = 0;
    end else begin
      src = mCtrl & 7;
      ps = (mCtrl >> 3) & 7;
      if (ps > 5) ps = 5;
      lim = (1 << (2 * ps)) - 1;
      tick = (src == 1) || (src == 2 && r2 && !r3) || (src == 4 && e2 && !e3);
      act = mRun && !mGated;
      div = act && tick && (mPre == lim);
      load = wrEn && addr == 2;
      restart = (wrEn && addr == 0 && !mGated && (int'(wdata & 63) != mCtrl)) ||
                (wrEn && addr == 6 && wdata[0] && !mRun) ||
                (wrEn && addr == 7 && wdata[0] && mRun);
      nxt = (mCount == mFull) ? 0 : ((mCount + 1) & 65535);
      mDone = div && !load && (nxt == mFull);
      if (restart) mPre = 0;
      else if (act && tick) mPre = div ? 0 : mPre + 1;
      if (load) mCount = int'(wdata & 65535);
      else if (div) mCount = nxt;
      if (wrEn && addr == 0 && !mGated) mCtrl = int'(wdata & 63);
      if (wrEn && addr == 1) mFull = int'(wdata & 65535);
      if (wrEn && addr == 3 && wdata[0]) mGated = 1;
      if (wrEn && addr == 4 && wdata[0]) mGated = 0;
      if (wrEn && addr == 6 && wdata[0]) mRun = 1;
      if (wrEn && addr == 7 && wdata[0]) mRun = 0;
      r3 = r2; r2 = r1; r1 = rtcClkIn;
      e3 = e2; e2 = e1; e1 = extClkIn;
    end
  end

  function automatic longint mRead(int a);
    case (a)
      0: return longint'(mCtrl);
      1: return longint'(mFull);
      2: return longint'(mCount);
      5: return longint'(mRun * 2 + mGated);
      default: return 0;
    endcase
  endfunction

  task automatic chk(string req, longint got, longint exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
    end
  endtask

  // Per-cycle comparison against the model
  initial begin
    forever begin
      @(negedge clk);
      #4;
      if (rstN) begin
        case (addr)
          3'd0: chk("R5 ctrl", longint'(rdata), mRead(0));
          3'd2: chk("R8 R12 count", longint'(rdata), mRead(2));
          3'd5: chk("R3 R4 status", longint'(rdata), mRead(5));
          default: chk("R2 read", longint'(rdata), mRead(int'(addr)));
        endcase
        chk("R9 doneSet", longint'(doneSet), longint'(mDone));
        if (doneSet) doneCnt++;
      end
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    wrEn = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wrEn = 1'b0; wdata = 32'd0;
  endtask

  task automatic rd(logic [2:0] a, output longint v);
    addr = a;
    #1;
    v = longint'(rdata);
  endtask

  task automatic finishUp();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    finishUp();
  end

  initial begin
    longint v, a, b;
    int base;
    idle(3);
    chk("R1 doneSet in reset", longint'(doneSet), 0);
    rstN = 1'b1;
    idle(1);
    // R1 reset values
    rd(0, v); chk("R1 ctrl", v, 0);
    rd(1, v); chk("R1 full", v, 'hFFFF);
    rd(2, v); chk("R1 count", v, 0);
    rd(5, v); chk("R1 status", v, 1);
    // R5 gated control write ignored
    wr(0, 32'h1);
    rd(0, v); chk("R5 gated write", v, 0);
    // R2 strobe registers read 0
    rd(3, v); chk("R2 addr3", v, 0);
    rd(4, v); chk("R2 addr4", v, 0);
    rd(6, v); chk("R2 addr6", v, 0);
    rd(7, v); chk("R2 addr7", v, 0);
    // R3 ungate
    wr(4, 32'h1);
    rd(5, v); chk("R3 ungated", v, 0);
    wr(0, 32'h1);
    rd(0, v); chk("R5 accepted", v, 1);
    // R4 enable, R9 periodic match
    wr(1, 32'd3);
    wr(6, 32'h1);
    rd(5, v); chk("R4 enabled", v, 2);
    base = doneCnt;
    idle(40);
    chk("R9 pulses", longint'(doneCnt - base), 10);
    // R8 gate stops counting; R3 status
    wr(3, 32'h1);
    rd(5, v); chk("R3 gated", v, 3);
    rd(2, a); idle(50); rd(2, b);
    chk("R8 gated hold", b, a);
    wr(4, 32'h1);
    // R8 disable stops counting
    wr(7, 32'h1);
    rd(5, v); chk("R4 disabled", v, 0);
    rd(2, a); idle(30); rd(2, b);
    chk("R8 disabled hold", b, a);
    // R7 divide by 16
    wr(1, 32'hFFFF);
    wr(0, (32'd2 << 3) | 32'd1);
    wr(2, 32'd0);
    wr(6, 32'h1);
    rd(2, a); idle(160); rd(2, b);
    chk("R7 div16", (b - a) & 'hFFFF, 10);
    // R12 restart on smaller ratio
    idle(10);
    wr(0, (32'd1 << 3) | 32'd1);
    rd(2, a); idle(8); rd(2, b);
    chk("R12 restart", (b - a) & 'hFFFF, 2);
    // R7 clamp 7 -> 1024
    wr(0, (32'd7 << 3) | 32'd1);
    rd(2, a); idle(2048); rd(2, b);
    chk("R7 clamp", (b - a) & 'hFFFF, 2);
    // R10 wrap at 0xFFFF
    wr(0, 32'd1);
    wr(2, 32'hFFFD);
    base = doneCnt;
    idle(8);
    chk("R10 one pulse", longint'(doneCnt - base), 1);
    rd(2, v); chk("R10 wrapped", v, 5);
    // R11 load while running
    wr(2, 32'd100);
    rd(2, v); chk("R11 load", v, 100);
    // R6 illegal source
    wr(0, 32'd3);
    rd(2, a); idle(20); rd(2, b);
    chk("R6 illegal code", b, a);
    // R13 external source pulses
    wr(0, 32'd4);
    rd(2, a);
    for (int i = 0; i < 10; i++) begin
      extClkIn = 1'b1; idle(4); extClkIn = 1'b0; idle(4);
    end
    idle(4);
    rd(2, b);
    chk("R13 ext edges", (b - a) & 'hFFFF, 10);
    // R13 rtc source pulses
    wr(0, 32'd2);
    rd(2, a);
    for (int i = 0; i < 6; i++) begin
      rtcClkIn = 1'b1; idle(5); rtcClkIn = 1'b0; idle(3);
    end
    idle(4);
    rd(2, b);
    chk("R13 R6 rtc edges", (b - a) & 'hFFFF, 6);
    idle(5);
    finishUp();
  end

endmodule